// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a small word-addressed cache that sits between a processor port and a main-memory port. It holds four lines of two words each. Every address has exactly one line it can occupy. Reads and writes that hit are served from the line store. A miss evicts whatever occupies the indexed line, copies that line to memory first if it was modified, and then brings in the requested block.

The processor raises a request and holds it, with its address and write data, until a one-cycle ready pulse comes back. On a read, that pulse carries the data. The memory side issues one word transfer at a time and keeps it steady until the memory acknowledges it, so memory latency may vary from access to access. An external flush pulse invalidates every line. Modified data held in flushed lines is dropped and never reaches memory.

Top module: `dmc_cache`

## Requirements
- R1: A 6-bit word address splits into tag = addr[5:3], line index = addr[2:1] and word-in-line = addr[0]. Memory transfers use the same layout, so a written-back word goes to {stored tag, index, word}.
- R2: After reset every line is invalid, so the first access to any address misses and fetches from memory. After reset, cpu_ready and mem_req are 0.
- R3: A read that hits (line valid and stored tag equal to the address tag) returns the cached word with cpu_ready high in the cycle after the request is accepted, and it makes no memory transfer.
- R4: A write that hits replaces the addressed word and marks the line modified, with no memory transfer. A later read of that word returns the new value.
- R5: On a miss whose victim line is valid and modified, the two victim words are written to memory, word 0 first, before any fill read is issued.
- R6: On a miss whose victim is clean or invalid, no memory write occurs.
- R7: A read miss reads the two block words from memory, word 0 first, then installs the block as valid and unmodified with the new tag, and returns the requested word.
- R8: A write miss fills the block from memory, merges in the written word, and leaves the line valid and modified. The other word of the block keeps its memory value.
- R9: Two tags that share an index evict each other, so alternating accesses to them miss every time.
- R10: A flush pulse accepted while idle clears every valid bit. Modified data in those lines is discarded without any write-back, and a later access to it misses and returns the memory value.
- R11: cpu_ready is a single-cycle pulse, and there is exactly one pulse per accepted request.
- R12: mem_req stays high with a constant address, direction and write data until mem_ack, and memory latency may be any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines (taken when idle) |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Word address |
| cpu_wdata | input | 8 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 6 | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Transfer done; one cycle |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |

## Verification
A hit raises cpu_ready exactly one cycle after the edge that accepts the request. A miss raises it one cycle after the edge that takes the final fill acknowledge, so its timing follows the memory latency. The bench drives and samples only on falling edges and measures hit latency in cycles from the edge of acceptance. For every access, the monitor compares the memory write count, the read count and the first memory address against a reference model of the line states. Memory latency takes the values 0 to 3 cycles between phases, and the final memory image is compared word by word against the model.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    parameter int unsigned TAG_W  = 3;
    parameter int unsigned IDX_W  = 2;
    parameter int unsigned OFF_W  = 1;
    parameter int unsigned DATA_W = 8;

    localparam int unsigned ADDR_W = TAG_W + IDX_W + OFF_W;
    localparam int unsigned LINES  = 1 << IDX_W;
    localparam int unsigned WORDS  = 1 << OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic                         valid;
        logic                         dirty;
        logic [TAG_W-1:0]             tag;
        logic [WORDS-1:0][DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        state_e                       st;
        logic [OFF_W-1:0]             cnt;
        logic                         we;
        logic [ADDR_W-1:0]            addr;
        logic [DATA_W-1:0]            wdata;
        logic [WORDS-1:0][DATA_W-1:0] fill;
        logic [DATA_W-1:0]            rdata;
    } ctrl_regs_t;
endpackage

// File: rtl/dmc_store.sv
module dmc_store
    import dmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_en,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);
    line_t [LINES-1:0] lines_all;
    logic  [LINES-1:0] valid_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (flush_en) begin
                line_d.valid = 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                line_d = wr_line;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= line_d;
        end

        assign lines_all[g] = line_q;
        assign valid_vec[g] = line_q.valid;
    end

    assign rd_line = lines_all[rd_idx];

    // R10: after a flush no line may still be valid
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (valid_vec == '0));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  st_rd_idx,
    input  line_t             st_line,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output line_t             st_wr_line,
    output logic              st_flush
);
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

    ctrl_regs_t r_d, r_q;
    line_t      new_line;

    logic [TAG_W-1:0] in_tag, l_tag;
    logic [IDX_W-1:0] in_idx, l_idx;
    logic [OFF_W-1:0] in_off, l_off;
    logic             hit;

    assign in_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign in_idx = cpu_addr[OFF_W +: IDX_W];
    assign in_off = cpu_addr[OFF_W-1:0];
    assign l_tag  = r_q.addr[ADDR_W-1 -: TAG_W];
    assign l_idx  = r_q.addr[OFF_W +: IDX_W];
    assign l_off  = r_q.addr[OFF_W-1:0];

    assign st_rd_idx = (r_q.st == ST_IDLE) ? in_idx : l_idx;
    assign hit       = st_line.valid && (st_line.tag == in_tag);

    always_comb begin
        r_d        = r_q;
        new_line   = st_line;
        st_wr_en   = 1'b0;
        st_wr_idx  = l_idx;
        st_wr_line = st_line;
        st_flush   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (flush) begin
                    st_flush = 1'b1;
                end else if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    r_d.cnt   = '0;
                    if (hit) begin
                        r_d.st = ST_RESP;
                        if (cpu_we) begin
                            st_wr_en                   = 1'b1;
                            st_wr_idx                  = in_idx;
                            st_wr_line.data[in_off]    = cpu_wdata;
                            st_wr_line.dirty           = 1'b1;
                            r_d.rdata                  = cpu_wdata;
                        end else begin
                            r_d.rdata = st_line.data[in_off];
                        end
                    end else if (st_line.valid && st_line.dirty) begin
                        r_d.st = ST_WBACK;
                    end else begin
                        r_d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {st_line.tag, l_idx, r_q.cnt};
                mem_wdata = st_line.data[r_q.cnt];
                if (mem_ack) begin
                    if (r_q.cnt == LAST_WORD) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_FILL;
                    end else begin
                        r_d.cnt = OFF_W'(r_q.cnt + 1);
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {l_tag, l_idx, r_q.cnt};
                if (mem_ack) begin
                    r_d.fill[r_q.cnt] = mem_rdata;
                    if (r_q.cnt == LAST_WORD) begin
                        new_line.valid = 1'b1;
                        new_line.dirty = r_q.we;
                        new_line.tag   = l_tag;
                        new_line.data  = r_d.fill;
                        if (r_q.we) new_line.data[l_off] = r_q.wdata;
                        st_wr_en   = 1'b1;
                        st_wr_line = new_line;
                        r_d.rdata  = new_line.data[l_off];
                        r_d.cnt    = '0;
                        r_d.st     = ST_RESP;
                    end else begin
                        r_d.cnt = OFF_W'(r_q.cnt + 1);
                    end
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready = (r_q.st == ST_RESP);
    assign cpu_rdata = r_q.rdata;

    // R11: completion is a single-cycle pulse
    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R12: a pending memory transfer is held steady until acknowledged
    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6: memory writes only ever carry a valid, modified victim
    assert_wb_dirty_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (st_line.valid && st_line.dirty));

    // R3: no memory traffic while completing a request
    assert_no_mem_on_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [IDX_W-1:0] st_rd_idx, st_wr_idx;
    line_t            st_line, st_wr_line;
    logic             st_wr_en, st_flush;

    dmc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .st_rd_idx  (st_rd_idx),
        .st_line    (st_line),
        .st_wr_en   (st_wr_en),
        .st_wr_idx  (st_wr_idx),
        .st_wr_line (st_wr_line),
        .st_flush   (st_flush)
    );

    dmc_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_en (st_flush),
        .rd_idx   (st_rd_idx),
        .rd_line  (st_line),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_line  (st_wr_line)
    );
endmodule

// File: tb/sim_dmc_cache.sv
module sim_dmc_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       cpu_req = 1'b0;
    logic       cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_ready;
    logic [7:0] cpu_rdata;
    logic       mem_req, mem_we;
    logic [5:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_ack = 1'b0;
    logic [7:0] mem_rdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    dmc_cache u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0, cycle = 0, issue_cyc = 0;
    int lat = 0, wait_cnt = 0, n_wr = 0, n_rd = 0;
    logic       first_seen = 1'b0;
    logic [5:0] first_addr = '0;

    logic [7:0] mem_arr [64];
    logic [7:0] ref_mem [64];
    logic       ref_valid [4];
    logic       ref_dirty [4];
    logic [2:0] ref_tag   [4];
    logic [7:0] ref_data  [4][2];

    bit         q_rd    [$];
    logic [7:0] q_data  [$];
    int         q_nwr   [$];
    int         q_nrd   [$];
    bit         q_chkf  [$];
    logic [5:0] q_first [$];
    int         q_lat   [$];
    string      q_name  [$];

    task automatic chk(input int act, input int exp, input string rq, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) cycle++;

    // memory model with programmable latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                wait_cnt = 0;
                mem_ack  = 1'b1;
                if (!first_seen) begin
                    first_seen = 1'b1;
                    first_addr = mem_addr;
                end
                if (mem_we) begin
                    mem_arr[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem_arr[mem_addr];
                    n_rd++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    // monitor: pop expected item on each completion
    always @(negedge clk) begin
        if (rst_n && cpu_ready) begin
            if (q_rd.size() == 0) begin
                chk(1, 0, "R11", "unexpected ready pulse");
            end else begin
                automatic bit         e_rd = q_rd.pop_front();
                automatic logic [7:0] e_d  = q_data.pop_front();
                automatic int         e_w  = q_nwr.pop_front();
                automatic int         e_r  = q_nrd.pop_front();
                automatic bit         e_cf = q_chkf.pop_front();
                automatic logic [5:0] e_f  = q_first.pop_front();
                automatic int         e_l  = q_lat.pop_front();
                automatic string      e_n  = q_name.pop_front();
                if (e_rd) chk(int'(cpu_rdata), int'(e_d), e_n, "read data");
                chk(n_wr, e_w, e_n, "memory write count");
                chk(n_rd, e_r, e_n, "memory read count");
                if (e_cf) chk(int'(first_addr), int'(e_f), e_n, "first memory address");
                if (e_l >= 0) chk(cycle - issue_cyc, e_l, e_n, "hit latency");
            end
        end
    end

    task automatic access(input bit we, input logic [5:0] addr, input logic [7:0] wd, input string rq);
        logic [2:0] tg;
        logic [1:0] ix;
        logic       of;
        bit         hit;
        int         nw;
        tg  = addr[5:3];
        ix  = addr[2:1];
        of  = addr[0];
        hit = ref_valid[ix] && (ref_tag[ix] == tg);
        nw  = (!hit && ref_valid[ix] && ref_dirty[ix]) ? 2 : 0;
        q_nwr.push_back(nw);
        q_nrd.push_back(hit ? 0 : 2);
        q_chkf.push_back(!hit);
        q_first.push_back((nw != 0) ? {ref_tag[ix], ix, 1'b0} : {tg, ix, 1'b0});
        q_lat.push_back(hit ? 1 : -1);
        q_name.push_back(rq);
        if (!hit) begin
            if (nw != 0) begin
                ref_mem[{ref_tag[ix], ix, 1'b0}] = ref_data[ix][0];
                ref_mem[{ref_tag[ix], ix, 1'b1}] = ref_data[ix][1];
            end
            ref_data[ix][0] = ref_mem[{tg, ix, 1'b0}];
            ref_data[ix][1] = ref_mem[{tg, ix, 1'b1}];
            ref_tag[ix]   = tg;
            ref_valid[ix] = 1'b1;
            ref_dirty[ix] = 1'b0;
        end
        if (we) begin
            ref_data[ix][of] = wd;
            ref_dirty[ix]    = 1'b1;
        end
        q_rd.push_back(!we);
        q_data.push_back(ref_data[ix][of]);

        @(negedge clk);
        n_wr = 0;
        n_rd = 0;
        first_seen = 1'b0;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        issue_cyc = cycle;
        do @(negedge clk); while (!cpu_ready);
        cpu_req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 4; i++) ref_valid[i] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem_arr[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 4; i++) begin
            ref_valid[i] = 1'b0;
            ref_dirty[i] = 1'b0;
            ref_tag[i]   = '0;
            ref_data[i][0] = '0;
            ref_data[i][1] = '0;
        end
        repeat (3) @(negedge clk);
        chk(int'(cpu_ready), 0, "R2", "cpu_ready in reset");
        chk(int'(mem_req), 0, "R2", "mem_req in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(cpu_ready), 0, "R2", "cpu_ready after reset");

        lat = 0;
        access(1'b0, 6'h20, 8'h00, "R2_R7 first read miss");
        access(1'b0, 6'h21, 8'h00, "R3 read hit");
        access(1'b1, 6'h21, 8'hA5, "R4 write hit");
        access(1'b0, 6'h21, 8'h00, "R4 read after write hit");

        lat = 3;
        access(1'b0, 6'h10, 8'h00, "R5_R12 dirty victim");
        access(1'b0, 6'h21, 8'h00, "R6_R1 clean victim, written-back data");
        access(1'b0, 6'h11, 8'h00, "R9 conflict a");
        access(1'b0, 6'h20, 8'h00, "R9 conflict b");
        access(1'b0, 6'h10, 8'h00, "R9 conflict c");

        lat = 1;
        access(1'b1, 6'h0B, 8'h3C, "R8 write miss");
        access(1'b0, 6'h0A, 8'h00, "R8 other word from memory");
        access(1'b0, 6'h0B, 8'h00, "R8 merged word");
        do_flush();
        access(1'b0, 6'h0B, 8'h00, "R10 flushed dirty data discarded");
        access(1'b0, 6'h11, 8'h00, "R10 miss after flush");

        lat = 2;
        access(1'b1, 6'h35, 8'h11, "R8_R12 write miss");
        access(1'b1, 6'h05, 8'h22, "R5_R8 dirty write miss");
        access(1'b0, 6'h35, 8'h00, "R5_R11 dirty read miss");
        access(1'b0, 6'h05, 8'h00, "R5 returns written-back word");

        repeat (4) @(negedge clk);
        chk(q_rd.size(), 0, "R11", "outstanding completions");
        begin
            automatic int bad = 0;
            for (int i = 0; i < 64; i++) if (mem_arr[i] !== ref_mem[i]) bad++;
            chk(bad, 0, "R1_R5", "memory words differing from model");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule